// File: doc/BRIEF.md
# ADC Result Post-Processing Accumulator

This block sits behind an analog-to-digital conversion engine and works on every conversion result that engine hands over. A three-bit mode input picks one operation: pass-through, running accumulation, averaging over a programmed sample count, burst averaging, or a first-order low-pass filter with unity gain. The block holds an accumulator, a sample counter, a sticky overflow flag, a filtered output register, a copy of the last raw result and a previous-sample register.

One three-bit shift input does two jobs. In the summing modes it is the power-of-two divisor applied to the accumulator. In filter mode it is the exponent of the filter time constant. A clear command zeroes the accumulator, the counter and the overflow flag. The clear then stays busy for a fixed number of cycles, and the busy output reads 1 for that whole time. When a conversion starts, the previous-sample register is loaded from either the raw result or the filtered output. The previous-source input picks which one.

Averages are exact only when the repeat count equals 2^shift. Average mode and burst mode process results in the same way; they differ only in how conversions are triggered, which is not part of this block.

Top module: `adc_postproc_acc`

## Requirements
- R1: Reset sets every output to 0. Mode 0 is then in force: mode 000 is pass-through.
- R2: In pass-through (000) and in the reserved modes (101, 110, 111), an accepted sample is copied to the filtered output and done pulses. The shift input has no effect in these modes. The accumulator and the counter do not change.
- R3: In accumulate mode (001), each accepted sample is added to the accumulator and the counter goes up by one. The filtered output becomes the new accumulator shifted right by the shift input, and done pulses.
- R4: In average mode (010) and burst mode (011), each sample is added and counted. When the counter reaches the repeat count, the filtered output takes the accumulator shifted right by the shift input and done pulses. On that sample the accumulator and counter are not reset. The next accepted sample restarts them, so the accumulator equals that sample and the counter equals 1.
- R5: In low-pass mode (100), each sample sets acc = acc + sample - (acc >> shift). The filtered output becomes acc >> shift, the counter goes up by one, and done pulses.
- R6: If an addition would go past the accumulator's maximum value, the accumulator saturates at its all-ones value and the overflow flag sets. The flag stays set until a clear. The counter stops at its all-ones value.
- R7: A clear request accepted while not busy zeroes the accumulator, the counter and the overflow flag at that clock edge. The busy output then reads 1 for exactly CLR_CYCLES cycles. A request made while busy is ignored.
- R8: A sample that arrives while busy, or on the same edge as an accepted clear request, changes neither the accumulator nor the counter.
- R9: With no accepted sample, the accumulator and the counter hold their values, and done stays 0 in the following cycle.
- R10: On a conversion-start strobe, the previous-sample output is loaded from one of two sources. With the previous-source input at 1, it takes the filtered output. With it at 0, it takes the last raw sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | A new conversion result is present this cycle |
| sample_data | input | DATA_W | Conversion result value |
| conv_start | input | 1 | Start-of-conversion strobe; loads the previous-sample register |
| mode | input | 3 | Operation select |
| shift_sel | input | 3 | Right-shift amount, or filter time-constant exponent |
| prev_src_sel | input | 1 | Previous-sample source: 1 filtered output, 0 raw sample |
| clear_req | input | 1 | Clear command |
| repeat_cnt | input | CNT_W | Number of samples per average |
| acc_o | output | ACC_W | Accumulator |
| cnt_o | output | CNT_W | Sample counter |
| ovf_o | output | 1 | Sticky accumulator overflow |
| filt_o | output | ACC_W | Filtered or shifted result |
| prev_o | output | ACC_W | Previous-sample register |
| clear_busy_o | output | 1 | Clear in progress (the command bit reads 1) |
| done_o | output | 1 | One-cycle pulse when a result is produced |

## Verification
The hardest state to reach from the ports is accumulator saturation. With full-scale 10-bit samples and an 18-bit accumulator, it takes 257 back-to-back accumulations. The bench therefore drives a long run of full-scale samples and checks the values just before and just after the limit. A close second is a sample that lands inside the clear's busy window. The bench asserts the clear and then places a sample in the very next cycle, while busy is still 1. Finally, the restart after a completed average only shows on the sample after done. The bench therefore checks the accumulator and counter one sample past each average.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

    typedef enum logic [2:0] {
        MODE_PASS  = 3'b000,
        MODE_ACCUM = 3'b001,
        MODE_AVG   = 3'b010,
        MODE_BURST = 3'b011,
        MODE_LPF   = 3'b100
    } pp_mode_e;

    function automatic logic mode_is_avg(input logic [2:0] m);
        return (m == MODE_AVG) || (m == MODE_BURST);
    endfunction

    function automatic logic mode_is_summing(input logic [2:0] m);
        return (m == MODE_ACCUM) || mode_is_avg(m) || (m == MODE_LPF);
    endfunction

endpackage

// File: rtl/adc_pp_arith.sv
module adc_pp_arith #(
    parameter int DATA_W = 10,
    parameter int ACC_W  = 18
) (
    input  logic [ACC_W-1:0]  acc_base,
    input  logic [DATA_W-1:0] sample,
    input  logic [2:0]        shift,
    input  logic              leak_en,
    output logic [ACC_W-1:0]  acc_next,
    output logic              sat_hit,
    output logic [ACC_W-1:0]  acc_shr
);
    localparam int EXT_W = ACC_W + 1;

    logic [EXT_W-1:0] base_x;
    logic [EXT_W-1:0] samp_x;
    logic [EXT_W-1:0] leak_x;
    logic [EXT_W-1:0] sum_x;

    always_comb begin
        base_x = {1'b0, acc_base};
        samp_x = EXT_W'(sample);
        // leak never exceeds acc_base, so the subtraction cannot wrap
        leak_x = leak_en ? {1'b0, (acc_base >> shift)} : '0;
        sum_x  = base_x + samp_x - leak_x;
        sat_hit  = sum_x[ACC_W];
        acc_next = sat_hit ? {ACC_W{1'b1}} : sum_x[ACC_W-1:0];
        acc_shr  = acc_next >> shift;
    end

endmodule

// File: rtl/adc_pp_clear_seq.sv
module adc_pp_clear_seq #(
    parameter int CLR_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_req,
    output logic start_o,
    output logic busy_o
);
    localparam int CW = $clog2(CLR_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] left;
    } clr_state_t;

    clr_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        start_o = clear_req && !s_q.busy;
        if (start_o) begin
            s_d.busy = 1'b1;
            s_d.left = CW'(CLR_CYCLES - 1);
        end else if (s_q.busy) begin
            if (s_q.left == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.left = s_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;

endmodule

// File: rtl/adc_postproc_acc.sv
module adc_postproc_acc
    import adc_pp_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int ACC_W      = 18,
    parameter int CNT_W      = 8,
    parameter int CLR_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_data,
    input  logic              conv_start,
    input  logic [2:0]        mode,
    input  logic [2:0]        shift_sel,
    input  logic              prev_src_sel,
    input  logic              clear_req,
    input  logic [CNT_W-1:0]  repeat_cnt,
    output logic [ACC_W-1:0]  acc_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_o,
    output logic [ACC_W-1:0]  filt_o,
    output logic [ACC_W-1:0]  prev_o,
    output logic              clear_busy_o,
    output logic              done_o
);
    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [ACC_W-1:0]  filt;
        logic [ACC_W-1:0]  prev;
        logic [DATA_W-1:0] raw;
        logic              done;
        logic              restart;
    } pp_state_t;

    pp_state_t s_d, s_q;

    logic             clr_start;
    logic             clr_busy;
    logic [ACC_W-1:0] arith_base;
    logic [ACC_W-1:0] arith_next;
    logic             arith_sat;
    logic [ACC_W-1:0] arith_shr;
    logic             avg_restart;
    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W-1:0] cnt_inc;
    logic             accept;

    adc_pp_clear_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (clear_req),
        .start_o   (clr_start),
        .busy_o    (clr_busy)
    );

    adc_pp_arith #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_arith (
        .acc_base (arith_base),
        .sample   (sample_data),
        .shift    (shift_sel),
        .leak_en  (mode == MODE_LPF),
        .acc_next (arith_next),
        .sat_hit  (arith_sat),
        .acc_shr  (arith_shr)
    );

    always_comb begin
        avg_restart = mode_is_avg(mode) && s_q.restart;
        arith_base  = avg_restart ? '0 : s_q.acc;
        cnt_base    = avg_restart ? '0 : s_q.cnt;
        cnt_inc     = (&cnt_base) ? cnt_base : cnt_base + 1'b1;
        accept      = sample_valid && !clr_busy && !clr_start;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        if (sample_valid) begin
            s_d.raw = sample_data;
        end

        if (clr_start) begin
            s_d.acc     = '0;
            s_d.cnt     = '0;
            s_d.ovf     = 1'b0;
            s_d.restart = 1'b0;
        end else if (accept) begin
            s_d.done = 1'b1;
            if (mode_is_summing(mode)) begin
                s_d.acc = arith_next;
                s_d.cnt = cnt_inc;
                s_d.ovf = s_q.ovf | arith_sat;
                if (mode_is_avg(mode)) begin
                    s_d.restart = (cnt_inc >= repeat_cnt);
                    s_d.done    = s_d.restart;
                    if (s_d.restart) begin
                        s_d.filt = arith_shr;
                    end
                end else begin
                    s_d.filt = arith_shr;
                end
            end else begin
                s_d.filt = ACC_W'(sample_data);
            end
        end

        if (conv_start) begin
            s_d.prev = prev_src_sel ? s_q.filt : ACC_W'(s_q.raw);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_o        = s_q.acc;
    assign cnt_o        = s_q.cnt;
    assign ovf_o        = s_q.ovf;
    assign filt_o       = s_q.filt;
    assign prev_o       = s_q.prev;
    assign done_o       = s_q.done;
    assign clear_busy_o = clr_busy;

endmodule

// File: rtl/adc_pp_checker.sv
module adc_pp_checker #(
    parameter int ACC_W = 18,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             clear_req,
    input logic [2:0]       mode,
    input logic [ACC_W-1:0] acc_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic             ovf_o,
    input logic             clear_busy_o,
    input logic             done_o
);
    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !clear_busy_o) |=> (acc_o == '0 && cnt_o == '0 && !ovf_o && clear_busy_o));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_busy_o |-> (acc_o == '0 && cnt_o == '0));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clear_req) |=> ovf_o);

    assert_done_needs_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid || clear_busy_o || clear_req) |=> !done_o);

    assert_acc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !clear_req) |=> ($stable(acc_o) && $stable(cnt_o)));

    assert_pass_no_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !clear_req && (mode == 3'b000)) |=> $stable(acc_o));

endmodule

bind adc_postproc_acc adc_pp_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .clear_req    (clear_req),
    .mode         (mode),
    .acc_o        (acc_o),
    .cnt_o        (cnt_o),
    .ovf_o        (ovf_o),
    .clear_busy_o (clear_busy_o),
    .done_o       (done_o)
);

// File: tb/tb_adc_postproc_acc.sv
`timescale 1ns/1ps
module tb_adc_postproc_acc;
    localparam int DATA_W = 10;
    localparam int ACC_W  = 18;
    localparam int CNT_W  = 8;
    localparam int CLR_CYCLES = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic [DATA_W-1:0] sample_data = '0;
    logic              conv_start = 1'b0;
    logic [2:0]        mode = 3'b000;
    logic [2:0]        shift_sel = 3'b000;
    logic              prev_src_sel = 1'b0;
    logic              clear_req = 1'b0;
    logic [CNT_W-1:0]  repeat_cnt = '0;
    logic [ACC_W-1:0]  acc_o;
    logic [CNT_W-1:0]  cnt_o;
    logic              ovf_o;
    logic [ACC_W-1:0]  filt_o;
    logic [ACC_W-1:0]  prev_o;
    logic              clear_busy_o;
    logic              done_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_postproc_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
        .conv_start(conv_start), .mode(mode), .shift_sel(shift_sel), .prev_src_sel(prev_src_sel),
        .clear_req(clear_req), .repeat_cnt(repeat_cnt), .acc_o(acc_o), .cnt_o(cnt_o),
        .ovf_o(ovf_o), .filt_o(filt_o), .prev_o(prev_o), .clear_busy_o(clear_busy_o), .done_o(done_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic put_sample(input logic [DATA_W-1:0] v);
        sample_valid = 1'b1;
        sample_data  = v;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic do_clear();
        clear_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear_req = 1'b0;
        repeat (CLR_CYCLES) @(negedge clk);
    endtask

    task automatic test_reset();
        check("R1 acc", acc_o, 0);
        check("R1 cnt", cnt_o, 0);
        check("R1 ovf", ovf_o, 0);
        check("R1 filt", filt_o, 0);
        check("R1 prev", prev_o, 0);
        check("R1 busy", clear_busy_o, 0);
        check("R1 done", done_o, 0);
    endtask

    task automatic test_pass();
        mode = 3'b000; shift_sel = 3'd5;
        put_sample(10'd300);
        check("R2 filt pass", filt_o, 300);
        check("R2 acc pass", acc_o, 0);
        check("R2 cnt pass", cnt_o, 0);
        check("R2 done pass", done_o, 1);
        mode = 3'b110;
        put_sample(10'd77);
        check("R2 filt reserved", filt_o, 77);
        check("R2 acc reserved", acc_o, 0);
        @(negedge clk);
        check("R9 done idle", done_o, 0);
    endtask

    task automatic test_accum();
        do_clear();
        mode = 3'b001; shift_sel = 3'd1;
        put_sample(10'd100);
        put_sample(10'd200);
        check("R3 acc", acc_o, 300);
        check("R3 cnt", cnt_o, 2);
        check("R3 filt", filt_o, 150);
        check("R3 done", done_o, 1);
        repeat (2) @(negedge clk);
        check("R9 acc hold", acc_o, 300);
        check("R9 cnt hold", cnt_o, 2);
    endtask

    task automatic test_overflow();
        do_clear();
        mode = 3'b001; shift_sel = 3'd0;
        for (int i = 0; i < 256; i++) put_sample(10'd1023);
        check("R6 acc before limit", acc_o, 261888);
        check("R6 ovf before limit", ovf_o, 0);
        check("R6 cnt stops", cnt_o, 255);
        put_sample(10'd1023);
        check("R6 acc saturates", acc_o, 262143);
        check("R6 ovf set", ovf_o, 1);
        put_sample(10'd5);
        check("R6 acc stays", acc_o, 262143);
        check("R6 ovf sticky", ovf_o, 1);
    endtask

    task automatic test_clear();
        clear_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear_req = 1'b0;
        check("R7 busy on", clear_busy_o, 1);
        check("R7 acc zero", acc_o, 0);
        check("R7 cnt zero", cnt_o, 0);
        check("R7 ovf zero", ovf_o, 0);
        put_sample(10'd500);
        check("R8 acc ignored", acc_o, 0);
        check("R8 cnt ignored", cnt_o, 0);
        check("R8 no done", done_o, 0);
        check("R7 busy still", clear_busy_o, 1);
        @(negedge clk);
        check("R7 busy third", clear_busy_o, 1);
        @(negedge clk);
        check("R7 busy off", clear_busy_o, 0);
        put_sample(10'd4);
        check("R7 acc after", acc_o, 4);
        check("R7 cnt after", cnt_o, 1);
    endtask

    task automatic test_average();
        do_clear();
        mode = 3'b010; shift_sel = 3'd2; repeat_cnt = 8'd4;
        put_sample(10'd10);
        put_sample(10'd20);
        put_sample(10'd30);
        check("R4 no done early", done_o, 0);
        check("R4 cnt 3", cnt_o, 3);
        put_sample(10'd40);
        check("R4 done", done_o, 1);
        check("R4 filt avg", filt_o, 25);
        check("R4 acc", acc_o, 100);
        check("R4 cnt 4", cnt_o, 4);
        put_sample(10'd8);
        check("R4 restart acc", acc_o, 8);
        check("R4 restart cnt", cnt_o, 1);
        check("R4 filt held", filt_o, 25);
        check("R4 done low", done_o, 0);
    endtask

    task automatic test_burst();
        do_clear();
        mode = 3'b011; shift_sel = 3'd1; repeat_cnt = 8'd2;
        put_sample(10'd5);
        put_sample(10'd7);
        check("R4 burst filt", filt_o, 6);
        check("R4 burst done", done_o, 1);
        put_sample(10'd9);
        check("R4 burst restart acc", acc_o, 9);
        check("R4 burst restart cnt", cnt_o, 1);
    endtask

    task automatic test_lpf();
        do_clear();
        mode = 3'b100; shift_sel = 3'd2;
        put_sample(10'd100);
        check("R5 acc1", acc_o, 100);
        check("R5 filt1", filt_o, 25);
        put_sample(10'd100);
        check("R5 acc2", acc_o, 175);
        check("R5 filt2", filt_o, 43);
        put_sample(10'd100);
        check("R5 acc3", acc_o, 232);
        check("R5 filt3", filt_o, 58);
        check("R5 cnt", cnt_o, 3);
        check("R5 done", done_o, 1);
    endtask

    task automatic test_prev();
        conv_start = 1'b1; prev_src_sel = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 prev raw", prev_o, 100);
        prev_src_sel = 1'b1;
        @(posedge clk);
        @(negedge clk);
        conv_start = 1'b0;
        check("R10 prev filt", prev_o, 58);
        prev_src_sel = 1'b0;
        @(negedge clk);
        check("R10 prev holds", prev_o, 58);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_pass();
        test_accum();
        test_overflow();
        test_clear();
        test_average();
        test_burst();
        test_lpf();
        test_prev();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule